// File: doc/BRIEF.md
# Masked Burst Address Counter with Start-Address Wrap

This block generates burst addresses for one port of a synchronous memory. It keeps three registers: an address counter, a mask that chooses which low-order address bits take part in counting, and a mirror that holds the start address most recently loaded. On each clock edge it carries out one operation. The operations are master reset, counter reset, mask reset, counter load, mask load, increment and hold.

An increment changes only the bits that the mask selects. When the selected bits are already all ones, the increment does not roll them over to zero. It copies the mirror's selected bits back in, so a burst repeats from its start address without reloading. If mask bit 0 is clear, the counter steps by two and bit 0 keeps its value. The active-low interrupt goes low after an increment that leaves every selected bit at one. It stays at that level until a later operation changes it.

The mask is expected to be a contiguous run of ones that starts at bit 0, or at bit 1 when bit 0 is clear.

Top module: `burst_addr_gen`

## Requirements
- R1: While `master_rst_n` is low, the next edge clears the counter and mirror to zero, sets every mask bit to one and drives `cnt_int_n` high.
- R2: A counter load copies `load_data` into both the counter and the mirror and drives `cnt_int_n` high.
- R3: An increment with mask bit 0 set adds one to the masked field. With mask bit 0 clear it adds two and bit 0 keeps its value. Address bits outside the mask never change on an increment.
- R4: An increment with every masked bit at one replaces the masked bits with the mirror's masked bits. Continued increments repeat the climb and the wrap indefinitely.
- R5: After an increment, `cnt_int_n` is 0 if every masked bit of the new address is 1, and 1 otherwise.
- R6: A counter reset clears the counter and the mirror and drives `cnt_int_n` high.
- R7: A mask reset sets every mask bit to one, leaves the counter unchanged and drives `cnt_int_n` high.
- R8: A mask load copies `load_data` into the mask, leaves the counter unchanged and drives `cnt_int_n` high.
- R9: With no operation requested, the address and `cnt_int_n` keep their values.
- R10: When several requests arrive together, one operation is chosen in this order: master reset, counter reset, mask reset, counter load, mask load, increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| master_rst_n | input | 1 | Synchronous master reset, active low, highest priority |
| cnt_rst | input | 1 | Counter reset request (counter and mirror to zero) |
| mask_rst | input | 1 | Mask reset request (mask to all ones) |
| cnt_load | input | 1 | Counter load request from `load_data` |
| mask_load | input | 1 | Mask load request from `load_data` |
| incr | input | 1 | Increment request |
| load_data | input | ADDR_W | Value for counter or mask loads |
| addr | output | ADDR_W | Current counter address |
| cnt_int_n | output | 1 | Active-low counter interrupt |

## Verification
The bench builds the block with `ADDR_W` set to 6. At that width every contiguous mask can be swept, both those that start at bit 0 and those that start at bit 1, and each of the 64 start addresses can be tried under each mask. Each burst runs past its maximum, so the wrap to a nonzero mirror value, the step-by-two case and the interrupt at every field width are all visited. Directed sequences then set the interrupt and clear it with each clearing operation, apply conflicting requests together, and change the mask in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Operation selected for the current clock; listed from lowest to highest priority.
  typedef enum logic [2:0] {
    OP_HOLD     = 3'd0,
    OP_INC      = 3'd1,
    OP_MASK_LD  = 3'd2,
    OP_CNT_LD   = 3'd3,
    OP_MASK_CLR = 3'd4,
    OP_CNT_CLR  = 3'd5,
    OP_MASTER   = 3'd6
  } burst_op_e;

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_pkg::*;
(
  input  logic      master_rst_n,
  input  logic      cnt_rst,
  input  logic      mask_rst,
  input  logic      cnt_load,
  input  logic      mask_load,
  input  logic      incr,
  output burst_op_e op
);

  // The first request that is active, in priority order, wins.
  always_comb begin
    if (!master_rst_n)  op = OP_MASTER;
    else if (cnt_rst)   op = OP_CNT_CLR;
    else if (mask_rst)  op = OP_MASK_CLR;
    else if (cnt_load)  op = OP_CNT_LD;
    else if (mask_load) op = OP_MASK_LD;
    else if (incr)      op = OP_INC;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/burst_step.sv
module burst_step #(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] mirror,
  output logic [ADDR_W-1:0] nxt,
  output logic              at_max,
  output logic              nxt_full
);

  // Step is one when mask bit 0 counts, otherwise two.
  function automatic logic [ADDR_W-1:0] step_of(input logic [ADDR_W-1:0] m);
    return m[0] ? ADDR_W'(1) : ADDR_W'(2);
  endfunction

  // The field is full when every selected bit is one.
  function automatic logic field_full(input logic [ADDR_W-1:0] v,
                                      input logic [ADDR_W-1:0] m);
    return (v & m) == m;
  endfunction

  logic [ADDR_W-1:0] bumped;
  logic [ADDR_W-1:0] kept;

  always_comb begin
    at_max   = field_full(cur, mask);
    bumped   = ((cur & mask) + step_of(mask)) & mask;
    kept     = cur & ~mask;
    nxt      = kept | (at_max ? (mirror & mask) : bumped);
    nxt_full = field_full(nxt, mask);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              master_rst_n,
  input  logic              cnt_rst,
  input  logic              mask_rst,
  input  logic              cnt_load,
  input  logic              mask_load,
  input  logic              incr,
  input  logic [ADDR_W-1:0] load_data,
  output logic [ADDR_W-1:0] addr,
  output logic              cnt_int_n
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  burst_op_e         op_sel;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] mask_q;
  logic [ADDR_W-1:0] mirror_q;
  logic              int_n_q;
  logic [ADDR_W-1:0] step_nxt;
  logic              step_at_max;
  logic              step_full;

  burst_op_decode u_dec (
    .master_rst_n (master_rst_n),
    .cnt_rst      (cnt_rst),
    .mask_rst     (mask_rst),
    .cnt_load     (cnt_load),
    .mask_load    (mask_load),
    .incr         (incr),
    .op           (op_sel)
  );

  burst_step #(.ADDR_W(ADDR_W)) u_step (
    .cur      (cnt_q),
    .mask     (mask_q),
    .mirror   (mirror_q),
    .nxt      (step_nxt),
    .at_max   (step_at_max),
    .nxt_full (step_full)
  );

  always_ff @(posedge clk) begin
    unique case (op_sel)
      OP_MASTER: begin
        cnt_q    <= '0;
        mirror_q <= '0;
        mask_q   <= ALL_ONES;
        int_n_q  <= 1'b1;
      end
      OP_CNT_CLR: begin
        cnt_q    <= '0;
        mirror_q <= '0;
        int_n_q  <= 1'b1;
      end
      OP_MASK_CLR: begin
        mask_q  <= ALL_ONES;
        int_n_q <= 1'b1;
      end
      OP_CNT_LD: begin
        cnt_q    <= load_data;
        mirror_q <= load_data;
        int_n_q  <= 1'b1;
      end
      OP_MASK_LD: begin
        mask_q  <= load_data;
        int_n_q <= 1'b1;
      end
      OP_INC: begin
        cnt_q   <= step_nxt;
        int_n_q <= ~step_full;
      end
      default: begin
      end
    endcase
  end

  assign addr      = cnt_q;
  assign cnt_int_n = int_n_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input burst_op_e         op,
  input logic [ADDR_W-1:0] addr,
  input logic              cnt_int_n,
  input logic [ADDR_W-1:0] mask_q,
  input logic [ADDR_W-1:0] mirror_q,
  input logic [ADDR_W-1:0] load_data,
  input logic              at_max
);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CNT_LD |=> addr == $past(load_data) && mirror_q == $past(load_data) && cnt_int_n); // R2

  AST_HIGH_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_INC |=> (addr & ~mask_q) == ($past(addr) & ~mask_q)); // R3

  AST_WRAP_TO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_INC && at_max |=> (addr & mask_q) == (mirror_q & mask_q)); // R4

  AST_INT_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_INC |=> cnt_int_n == ((addr & mask_q) != mask_q)); // R5

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CNT_CLR |=> addr == '0 && mirror_q == '0 && cnt_int_n); // R6

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_MASK_CLR |=> mask_q == {ADDR_W{1'b1}} && $stable(addr) && cnt_int_n); // R7

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_MASK_LD |=> mask_q == $past(load_data) && $stable(addr) && cnt_int_n); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(addr) && $stable(cnt_int_n) && $stable(mask_q)); // R9

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (master_rst_n),
  .op        (op_sel),
  .addr      (addr),
  .cnt_int_n (cnt_int_n),
  .mask_q    (mask_q),
  .mirror_q  (mirror_q),
  .load_data (load_data),
  .at_max    (step_at_max)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

  localparam int AW = 6;
  localparam int FULL = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          master_rst_n = 1'b0;
  logic          cnt_rst = 1'b0;
  logic          mask_rst = 1'b0;
  logic          cnt_load = 1'b0;
  logic          mask_load = 1'b0;
  logic          incr = 1'b0;
  logic [AW-1:0] load_data = '0;
  logic [AW-1:0] addr;
  logic          cnt_int_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state.
  int m_cnt, m_mask, m_mir, m_int;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk          (clk),
    .master_rst_n (master_rst_n),
    .cnt_rst      (cnt_rst),
    .mask_rst     (mask_rst),
    .cnt_load     (cnt_load),
    .mask_load    (mask_load),
    .incr         (incr),
    .load_data    (load_data),
    .addr         (addr),
    .cnt_int_n    (cnt_int_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model increment: the counting field is a run of k bits starting at bit lo.
  task automatic model_inc(output bit wrapped);
    int lo, k, fmax, f, nf;
    lo = (m_mask & 1) ? 0 : 1;
    k = 0;
    for (int i = 0; i < AW; i++) if ((m_mask >> i) & 1) k++;
    fmax = (1 << k) - 1;
    f = (m_cnt >> lo) & fmax;
    wrapped = (f == fmax);
    nf = wrapped ? ((m_mir >> lo) & fmax) : f + 1;
    m_cnt = (m_cnt & ~(fmax << lo) & FULL) | (nf << lo);
    m_int = (nf == fmax) ? 0 : 1;
  endtask

  task automatic compare(input string tag);
    chk(int'(addr) == m_cnt, tag, int'(addr), m_cnt);
    chk(int'(cnt_int_n) == m_int, {tag, " int"}, int'(cnt_int_n), m_int);
  endtask

  // Apply one cycle of requests at a falling edge; check after the next falling edge.
  task automatic apply(input bit mr, input bit cr, input bit kr, input bit ld,
                       input bit kl, input bit inc, input int data, input string tag);
    bit wr;
    master_rst_n = ~mr; cnt_rst = cr; mask_rst = kr; cnt_load = ld;
    mask_load = kl; incr = inc; load_data = AW'(data);
    @(negedge clk);
    if (mr) begin m_cnt = 0; m_mir = 0; m_mask = FULL; m_int = 1; end
    else if (cr) begin m_cnt = 0; m_mir = 0; m_int = 1; end
    else if (kr) begin m_mask = FULL; m_int = 1; end
    else if (ld) begin m_cnt = data; m_mir = data; m_int = 1; end
    else if (kl) begin m_mask = data; m_int = 1; end
    else if (inc) model_inc(wr);
    master_rst_n = 1'b1; cnt_rst = 0; mask_rst = 0; cnt_load = 0;
    mask_load = 0; incr = 0;
    compare(tag);
  endtask

  task automatic do_inc(input string tag);
    apply(0, 0, 0, 0, 0, 1, 0, tag);
  endtask

  task automatic set_int_low(input int mask, input int start);
    apply(0, 0, 0, 0, 1, 0, mask, "R8 setup");
    apply(0, 0, 0, 1, 0, 0, start, "R2 setup");
    while (m_int != 0) do_inc("R5 setup");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: master reset state
    apply(1, 0, 0, 0, 0, 0, 0, "R1 reset");
    apply(1, 0, 0, 1, 0, 1, 9, "R1 reset over load");
    do_inc("R1 mask all ones after reset");

    // Sweep: every contiguous mask from bit 0 and from bit 1, every start value.
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w <= AW - s; w++) begin
        int mk, k;
        if (s == 1 && w == 0) continue;
        mk = ((1 << w) - 1) << s;
        k = w;
        apply(0, 0, 0, 0, 1, 0, mk, "R8 mask load");
        for (int st = 0; st < (1 << AW); st++) begin
          apply(0, 0, 0, 1, 0, 0, st, "R2 load");
          for (int n = 0; n < (1 << k) + 3; n++) begin
            bit at_top;
            at_top = ((m_cnt & mk) == mk);
            if (at_top) do_inc("R4 wrap");
            else if (s == 1) do_inc("R3 step by two");
            else do_inc("R3 step by one");
          end
        end
      end
    end

    // Interrupt cleared by each operation.
    set_int_low(7, 5);
    apply(0, 1, 0, 0, 0, 0, 0, "R6 counter reset");
    for (int n = 0; n < 9; n++) do_inc("R6 mirror cleared");
    set_int_low(7, 13);
    apply(0, 0, 0, 1, 0, 0, 42, "R2 load clears int");
    set_int_low(7, 13);
    apply(0, 0, 1, 0, 0, 0, 0, "R7 mask reset");
    do_inc("R7 full mask after reset");
    set_int_low(7, 13);
    apply(0, 0, 0, 0, 1, 0, 3, "R8 mask load clears int");
    set_int_low(7, 13);
    apply(1, 0, 0, 0, 0, 0, 0, "R1 master reset clears int");
    set_int_low(6, 9);
    for (int n = 0; n < 4; n++) apply(0, 0, 0, 0, 0, 0, 21, "R9 hold");

    // Priority among simultaneous requests.
    set_int_low(15, 3);
    apply(0, 1, 1, 1, 1, 1, 40, "R10 counter reset wins");
    apply(0, 0, 0, 0, 1, 0, 3, "R10 setup");
    apply(0, 0, 1, 0, 1, 1, 3, "R10 mask reset over mask load");
    for (int n = 0; n < 3; n++) do_inc("R10 mask full");
    apply(0, 0, 0, 1, 1, 1, 17, "R10 load over mask load");
    for (int n = 0; n < 3; n++) do_inc("R10 mask unchanged");
    apply(0, 0, 0, 0, 1, 1, 7, "R10 mask load over incr");
    do_inc("R10 after mask load");

    // Mask changed in the middle of a burst.
    apply(0, 0, 0, 0, 1, 0, 15, "R8 mid-burst setup");
    apply(0, 0, 0, 1, 0, 0, 35, "R2 mid-burst start");
    for (int n = 0; n < 5; n++) do_inc("R3 before change");
    apply(0, 0, 0, 0, 1, 0, 3, "R8 mid-burst mask");
    for (int n = 0; n < 6; n++) do_inc("R4 after narrow");
    apply(0, 0, 0, 0, 1, 0, 30, "R8 mid-burst even mask");
    for (int n = 0; n < 20; n++) do_inc("R3 after even mask");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule